// File: doc/BRIEF.md
# Two-Channel Cascaded Polynomial Phase Linearizer

This block turns a decimated phase reading into a linearized, temperature-like word. Each readout channel delivers one signed phase sample per decimation period. The block passes that sample through three polynomial corrections in series. The first is an odd fifth-order stage that cancels the cosine bend introduced by the demodulator. The second is a per-device gain-and-offset trim taken from a two-point calibration. The third is a fourth-order stage whose coefficients are common to every device and remove the leftover curvature. Each channel keeps its own set of ten coefficients. The sample's channel tag selects which set is applied.

Samples are very rare compared with the clock: a few hundred per second against a clock in the hundreds of megahertz. All arithmetic therefore runs on one shared signed multiply-accumulate unit, stepped through a fixed nine-step Horner program. The result is delivered as a one-cycle strobe with an 18-bit word and the channel tag. Software loads coefficients through a small write port, and a write only takes effect while the block is idle. A sample that arrives during a computation is discarded and sets a sticky flag.

Top module: `phase_linearizer`

## Requirements
- R1: After a synchronous active-high reset, out_valid and overrun are 0. Every channel holds the identity set: a1, gain and c1 equal 1.0 (4194304), and all other coefficients are 0. With this set, a sample produces the rounded input value at the output.
- R2: in_phase is a signed fraction with 21 fractional bits. Internally it becomes a 24-bit signed value with 22 fractional bits, equal to in_phase times 2.
- R3: Every product is rounded half-up to 22 fractional bits, floor((a·b + 2^21)/2^22), and then clamped to the signed 24-bit range. Every following addition is also clamped to that range.
- R4: The odd stage is evaluated in this order: s = x·x, t = a5·s + a3, t = t·s + a1, y = t·x.
- R5: The trim stage computes y = gain·y + offset.
- R6: The shared stage is evaluated in this order: t = c4·y + c3, then t = t·y + c2, then t = t·y + c1, then t = t·y + c0.
- R7: out_word is floor((t + 32)/64), clamped to the signed 18-bit range. out_chan repeats the tag of the sample that produced the word.
- R8: A sample is accepted on a clock edge where in_valid is 1 and the block is idle. out_valid is high for exactly one cycle, after the ninth edge following the accept edge. The block accepts again from the tenth edge onwards.
- R9: in_valid at any edge while the block is busy drops that sample and sets overrun. overrun then stays 1 until reset.
- R10: Coefficient index map: 0 is a1, 1 is a3, 2 is a5, 3 is gain, 4 is offset, and 5 to 9 are c0 to c4. A write is applied only at an edge where the block is idle. Writes while busy, and writes to indices 10 to 15, change nothing.
- R11: The two channels keep independent coefficient sets. A write to one channel never alters results on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 1 | Channel tag of the sample |
| in_phase | input | 22 | Signed decimated phase word |
| coef_we | input | 1 | Coefficient write strobe |
| coef_chan | input | 1 | Channel addressed by the write |
| coef_idx | input | 4 | Coefficient index |
| coef_data | input | 24 | Signed coefficient with 22 fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_chan | output | 1 | Channel tag of the result |
| out_word | output | 18 | Signed linearized word |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
The properties assume that every input is known whenever reset is low, and that reset is held for at least one rising edge before it is released. They place no limit on when samples or writes arrive. Busy-time strobes are therefore legal stimulus, and the flag and stability properties are written to cover them. The bench drives all inputs on falling edges from time zero. It then deliberately issues samples and coefficient writes during a computation, including a continuous in_valid burst that reaches the exact re-accept edge.

// File: rtl/linz_pkg.sv
package linz_pkg;

    localparam int unsigned LZ_NCOEF  = 10;
    localparam int unsigned LZ_NSTEP  = 9;
    localparam int unsigned LZ_IDX_W  = 4;
    localparam int unsigned LZ_STEP_W = 4;

    // coefficient slots, shared by the write port and the step program
    localparam logic [LZ_IDX_W-1:0] K_A1   = 4'd0;
    localparam logic [LZ_IDX_W-1:0] K_A3   = 4'd1;
    localparam logic [LZ_IDX_W-1:0] K_A5   = 4'd2;
    localparam logic [LZ_IDX_W-1:0] K_GAIN = 4'd3;
    localparam logic [LZ_IDX_W-1:0] K_OFS  = 4'd4;
    localparam logic [LZ_IDX_W-1:0] K_C0   = 4'd5;
    localparam logic [LZ_IDX_W-1:0] K_C1   = 4'd6;
    localparam logic [LZ_IDX_W-1:0] K_C2   = 4'd7;
    localparam logic [LZ_IDX_W-1:0] K_C3   = 4'd8;
    localparam logic [LZ_IDX_W-1:0] K_C4   = 4'd9;

    typedef enum logic [2:0] {OPD_X, OPD_X2, OPD_T, OPD_Y, OPD_COEF} opd_e;
    typedef enum logic [1:0] {DST_X2, DST_T, DST_Y}                  dst_e;
    typedef enum logic       {ST_IDLE, ST_RUN}                        lz_state_e;

    typedef struct packed {
        opd_e                src_a;
        logic [LZ_IDX_W-1:0] kidx_a;
        opd_e                src_b;
        logic                add_en;
        logic [LZ_IDX_W-1:0] kidx_add;
        dst_e                dst;
    } step_t;

    function automatic step_t mk(input opd_e a, input logic [LZ_IDX_W-1:0] ka,
                                 input opd_e b, input logic ae,
                                 input logic [LZ_IDX_W-1:0] kc, input dst_e d);
        step_t s;
        s.src_a = a; s.kidx_a = ka; s.src_b = b;
        s.add_en = ae; s.kidx_add = kc; s.dst = d;
        return s;
    endfunction

    // Horner program: odd stage, trim, shared curvature stage
    function automatic step_t step_of(input logic [LZ_STEP_W-1:0] n);
        case (n)
            4'd0:    return mk(OPD_X,    K_A1,   OPD_X,  1'b0, K_A1,  DST_X2);
            4'd1:    return mk(OPD_COEF, K_A5,   OPD_X2, 1'b1, K_A3,  DST_T);
            4'd2:    return mk(OPD_T,    K_A1,   OPD_X2, 1'b1, K_A1,  DST_T);
            4'd3:    return mk(OPD_T,    K_A1,   OPD_X,  1'b0, K_A1,  DST_Y);
            4'd4:    return mk(OPD_COEF, K_GAIN, OPD_Y,  1'b1, K_OFS, DST_Y);
            4'd5:    return mk(OPD_COEF, K_C4,   OPD_Y,  1'b1, K_C3,  DST_T);
            4'd6:    return mk(OPD_T,    K_C4,   OPD_Y,  1'b1, K_C2,  DST_T);
            4'd7:    return mk(OPD_T,    K_C4,   OPD_Y,  1'b1, K_C1,  DST_T);
            default: return mk(OPD_T,    K_C4,   OPD_Y,  1'b1, K_C0,  DST_T);
        endcase
    endfunction

    function automatic logic is_unity(input int k);
        return (k == int'(K_A1)) || (k == int'(K_GAIN)) || (k == int'(K_C1));
    endfunction

endpackage

// File: rtl/linz_mac.sv
module linz_mac #(
    parameter int unsigned OP_W   = 24,
    parameter int unsigned FRAC_W = 22
) (
    input  logic signed [OP_W-1:0] mul_a,
    input  logic signed [OP_W-1:0] mul_b,
    input  logic signed [OP_W-1:0] add_c,
    output logic signed [OP_W-1:0] res
);
    localparam int unsigned PW = 2 * OP_W + 1;
    localparam logic signed [PW-1:0] P_MAX  = PW'((64'sd1 <<< (OP_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] P_MIN  = ~P_MAX;
    localparam logic signed [PW-1:0] P_HALF = PW'(64'sd1 <<< (FRAC_W - 1));

    logic signed [PW-1:0]   prod, rounded, scaled;
    logic signed [OP_W-1:0] prod_q;
    logic signed [OP_W:0]   sum;

    always_comb begin
        prod    = PW'(mul_a) * PW'(mul_b);
        rounded = prod + P_HALF;
        scaled  = rounded >>> FRAC_W;
        if (scaled > P_MAX)
            prod_q = P_MAX[OP_W-1:0];
        else if (scaled < P_MIN)
            prod_q = P_MIN[OP_W-1:0];
        else
            prod_q = scaled[OP_W-1:0];

        sum = (OP_W+1)'(prod_q) + (OP_W+1)'(add_c);
        if (sum[OP_W] != sum[OP_W-1])
            res = sum[OP_W] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
        else
            res = sum[OP_W-1:0];
    end
endmodule

// File: rtl/linz_coef_bank.sv
module linz_coef_bank import linz_pkg::*; #(
    parameter int unsigned NCHAN  = 2,
    parameter int unsigned NCOEF  = LZ_NCOEF,
    parameter int unsigned OP_W   = 24,
    parameter int unsigned FRAC_W = 22,
    parameter int unsigned CH_W   = 1,
    parameter int unsigned IDX_W  = LZ_IDX_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [CH_W-1:0]             wr_chan,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [OP_W-1:0]             wr_data,
    input  logic [CH_W-1:0]             rd_chan,
    input  logic [IDX_W-1:0]            rd_idx_a,
    input  logic [IDX_W-1:0]            rd_idx_b,
    output logic [OP_W-1:0]             rd_a,
    output logic [OP_W-1:0]             rd_b,
    output logic [NCHAN*NCOEF*OP_W-1:0] all_q
);
    localparam logic [OP_W-1:0] ONE = OP_W'(1) << FRAC_W;

    logic [OP_W-1:0] mem [NCHAN][NCOEF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < int'(NCHAN); c++)
                for (int k = 0; k < int'(NCOEF); k++)
                    mem[c][k] <= is_unity(k) ? ONE : '0;
        end else if (wr_en) begin
            mem[wr_chan][wr_idx] <= wr_data;
        end
    end

    assign rd_a = mem[rd_chan][rd_idx_a];
    assign rd_b = mem[rd_chan][rd_idx_b];

    for (genvar c = 0; c < int'(NCHAN); c++) begin : g_ch
        for (genvar k = 0; k < int'(NCOEF); k++) begin : g_k
            assign all_q[(c*NCOEF+k)*OP_W +: OP_W] = mem[c][k];
        end
    end
endmodule

// File: rtl/linz_seq.sv
module linz_seq import linz_pkg::*; #(
    parameter int unsigned NSTEP  = LZ_NSTEP,
    parameter int unsigned STEP_W = LZ_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              busy,
    output logic              accept,
    output logic              overrun_set,
    output logic              last,
    output logic [STEP_W-1:0] step
);
    lz_state_e         state_q;
    logic [STEP_W-1:0] step_q;

    always_comb begin
        busy        = (state_q == ST_RUN);
        accept      = in_valid && !busy;
        overrun_set = in_valid && busy;
        last        = busy && (step_q == STEP_W'(NSTEP - 1));
        step        = step_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    step_q  <= '0;
                end
                default: if (last) begin
                    state_q <= ST_IDLE;
                    step_q  <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/phase_linearizer.sv
module phase_linearizer import linz_pkg::*; #(
    parameter int unsigned IN_W   = 22,
    parameter int unsigned OP_W   = 24,
    parameter int unsigned FRAC_W = 22,
    parameter int unsigned OUT_W  = 18,
    parameter int unsigned NCHAN  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [((NCHAN > 1) ? $clog2(NCHAN) : 1)-1:0] in_chan,
    input  logic [IN_W-1:0]         in_phase,
    input  logic                    coef_we,
    input  logic [((NCHAN > 1) ? $clog2(NCHAN) : 1)-1:0] coef_chan,
    input  logic [LZ_IDX_W-1:0]     coef_idx,
    input  logic [OP_W-1:0]         coef_data,
    output logic                    out_valid,
    output logic [((NCHAN > 1) ? $clog2(NCHAN) : 1)-1:0] out_chan,
    output logic [OUT_W-1:0]        out_word,
    output logic                    overrun
);
    localparam int unsigned CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1;
    localparam int unsigned SH    = FRAC_W - (IN_W - 1);
    localparam int unsigned OSH   = OP_W - OUT_W;
    localparam int unsigned ALL_W = NCHAN * LZ_NCOEF * OP_W;
    localparam logic signed [OP_W:0] O_HALF = (OP_W+1)'(64'sd1 <<< (OSH - 1));
    localparam logic signed [OP_W:0] O_MAX  = (OP_W+1)'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [OP_W:0] O_MIN  = ~O_MAX;

    logic                    busy, accept, ovr_set, last;
    logic [LZ_STEP_W-1:0]    step;
    step_t                   st;
    logic                    coef_wr;
    logic [OP_W-1:0]         coef_a, coef_b;
    logic [ALL_W-1:0]        coef_all;
    logic signed [OP_W-1:0]  x_in, x_q, x2_q, t_q, y_q;
    logic signed [OP_W-1:0]  opa, opb, addend, mac_y;
    logic [CH_W-1:0]         chan_q;
    logic signed [OP_W:0]    o_sum, o_shf;
    logic [OUT_W-1:0]        o_word;

    linz_seq #(.NSTEP(LZ_NSTEP), .STEP_W(LZ_STEP_W)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy), .accept(accept),
        .overrun_set(ovr_set), .last(last), .step(step)
    );

    assign coef_wr = coef_we && !busy && (coef_idx < LZ_IDX_W'(LZ_NCOEF));
    assign st      = step_of(step);

    linz_coef_bank #(
        .NCHAN(NCHAN), .NCOEF(LZ_NCOEF), .OP_W(OP_W), .FRAC_W(FRAC_W),
        .CH_W(CH_W), .IDX_W(LZ_IDX_W)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_en(coef_wr), .wr_chan(coef_chan),
        .wr_idx(coef_idx), .wr_data(coef_data), .rd_chan(chan_q),
        .rd_idx_a(st.kidx_a), .rd_idx_b(st.kidx_add),
        .rd_a(coef_a), .rd_b(coef_b), .all_q(coef_all)
    );

    assign x_in = OP_W'($signed(in_phase)) <<< SH;

    always_comb begin
        case (st.src_a)
            OPD_X:   opa = x_q;
            OPD_X2:  opa = x2_q;
            OPD_T:   opa = t_q;
            OPD_Y:   opa = y_q;
            default: opa = $signed(coef_a);
        endcase
        case (st.src_b)
            OPD_X2:  opb = x2_q;
            OPD_T:   opb = t_q;
            OPD_Y:   opb = y_q;
            default: opb = x_q;
        endcase
        addend = st.add_en ? $signed(coef_b) : '0;
    end

    linz_mac #(.OP_W(OP_W), .FRAC_W(FRAC_W)) u_mac (
        .mul_a(opa), .mul_b(opb), .add_c(addend), .res(mac_y)
    );

    always_comb begin
        o_sum = (OP_W+1)'(mac_y) + O_HALF;
        o_shf = o_sum >>> OSH;
        if (o_shf > O_MAX)
            o_word = O_MAX[OUT_W-1:0];
        else if (o_shf < O_MIN)
            o_word = O_MIN[OUT_W-1:0];
        else
            o_word = o_shf[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q       <= '0;
            x2_q      <= '0;
            t_q       <= '0;
            y_q       <= '0;
            chan_q    <= '0;
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_word  <= '0;
            overrun   <= 1'b0;
        end else begin
            if (accept) begin
                x_q    <= x_in;
                chan_q <= in_chan;
            end
            if (busy) begin
                case (st.dst)
                    DST_X2:  x2_q <= mac_y;
                    DST_T:   t_q  <= mac_y;
                    default: y_q  <= mac_y;
                endcase
            end
            out_valid <= last;
            if (last) begin
                out_word <= o_word;
                out_chan <= chan_q;
            end
            if (ovr_set)
                overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/phase_linearizer_chk.sv
module phase_linearizer_chk #(
    parameter int unsigned OUT_W = 18,
    parameter int unsigned ALL_W = 480
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word,
    input logic             overrun,
    input logic [ALL_W-1:0] coef_all
);
    // R8: the result strobe never lasts two cycles
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: a result only follows a busy cycle
    p_result_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy));

    // R8: an idle-time sample starts a computation
    p_accept_starts_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> busy);

    // R9: the flag never clears outside reset
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R9: the flag only rises after a busy-time sample
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(in_valid && busy));

    // R7: the word holds between result strobes
    p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_word));

    // R10: coefficients do not move during a computation
    p_coef_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(coef_all));
endmodule

bind phase_linearizer phase_linearizer_chk #(
    .OUT_W(OUT_W), .ALL_W(NCHAN * 10 * OP_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .out_word(out_word), .overrun(overrun),
    .coef_all(coef_all)
);

// File: tb/phase_linearizer_tb.sv
module phase_linearizer_tb;
    localparam int ONE_Q = 4194304;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [0:0]  in_chan = '0;
    logic [21:0] in_phase = '0;
    logic        coef_we = 1'b0;
    logic [0:0]  coef_chan = '0;
    logic [3:0]  coef_idx = '0;
    logic [23:0] coef_data = '0;
    logic        out_valid;
    logic [0:0]  out_chan;
    logic [17:0] out_word;
    logic        overrun;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    run_chk = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    phase_linearizer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_phase(in_phase), .coef_we(coef_we), .coef_chan(coef_chan),
        .coef_idx(coef_idx), .coef_data(coef_data), .out_valid(out_valid),
        .out_chan(out_chan), .out_word(out_word), .overrun(overrun)
    );

    // ---------------- behavioural reference ----------------
    longint coef [2][10];
    int     cnt;
    longint pend_word;
    int     pend_ch;
    bit     exp_valid, exp_ovr;
    longint exp_word;
    int     exp_ch;

    function automatic longint sat(input longint v, input int bits);
        longint hi = (64'sd1 <<< (bits - 1)) - 1;
        longint lo = -(64'sd1 <<< (bits - 1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic longint mulr(input longint a, input longint b);
        return sat((a * b + (64'sd1 <<< 21)) >>> 22, 24);
    endfunction

    function automatic longint adds(input longint a, input longint b);
        return sat(a + b, 24);
    endfunction

    function automatic longint evaluate(input int ch, input longint ph);
        longint x, s, t, y;
        x = ph * 2;
        s = mulr(x, x);
        t = adds(mulr(coef[ch][2], s), coef[ch][1]);
        t = adds(mulr(t, s), coef[ch][0]);
        y = mulr(t, x);
        y = adds(mulr(coef[ch][3], y), coef[ch][4]);
        t = adds(mulr(coef[ch][9], y), coef[ch][8]);
        t = adds(mulr(t, y), coef[ch][7]);
        t = adds(mulr(t, y), coef[ch][6]);
        t = adds(mulr(t, y), coef[ch][5]);
        return sat((t + 32) >>> 6, 18);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < 10; k++)
                    coef[c][k] = (k == 0 || k == 3 || k == 6) ? ONE_Q : 0;
            cnt = 0; exp_valid = 0; exp_ovr = 0; exp_word = 0; exp_ch = 0;
        end else begin
            exp_valid = 0;
            if (cnt == 0) begin
                if (coef_we && coef_idx < 10)
                    coef[coef_chan][coef_idx] = longint'($signed(coef_data));
                if (in_valid) begin
                    pend_word = evaluate(int'(in_chan), longint'($signed(in_phase)));
                    pend_ch   = int'(in_chan);
                    cnt = 9;
                end
            end else begin
                if (in_valid) exp_ovr = 1;
                cnt--;
                if (cnt == 0) begin
                    exp_valid = 1; exp_word = pend_word; exp_ch = pend_ch;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (run_chk) begin
            n_vec++;
            if (out_valid !== exp_valid || overrun !== exp_ovr ||
                (exp_valid && (out_word !== exp_word[17:0] || out_chan !== exp_ch[0:0]))) begin
                n_bad++;
                $display("FAIL %s: got valid=%0b word=%0d chan=%0d ovr=%0b, expected valid=%0b word=%0d chan=%0d ovr=%0b",
                         cur_req, out_valid, $signed(out_word), out_chan, overrun,
                         exp_valid, exp_word, exp_ch, exp_ovr);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input int ch, input int ph);
        @(negedge clk);
        in_valid = 1'b1; in_chan = 1'(ch); in_phase = 22'(ph);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wcoef(input int ch, input int idx, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_chan = 1'(ch); coef_idx = 4'(idx); coef_data = 24'(val);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic expect_word(input int ch, input int ph, input int want, input string tag);
        bit seen = 0;
        send(ch, ph);
        for (int k = 0; k < 12 && !seen; k++) begin
            if (out_valid) begin
                seen = 1;
                n_vec++;
                if ($signed(out_word) != want) begin
                    n_bad++;
                    $display("FAIL %s: word %0d, expected %0d", tag, $signed(out_word), want);
                end
            end
            if (!seen) @(negedge clk);
        end
        if (!seen) begin
            n_bad++;
            $display("FAIL %s: no result strobe, expected word %0d", tag, want);
        end
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    int seed = 32'h1234_5678;
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_chk = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        n_vec++;
        if (out_valid !== 1'b0 || overrun !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b ovr=%0b, expected 0 0", out_valid, overrun);
        end

        // R1 R2: identity set, hand-computed values
        cur_req = "R1 R2";
        expect_word(0, 1048576, 32768, "R1 R2 half scale");
        expect_word(1, -2097152, -65536, "R1 R2 negative full scale");
        expect_word(0, 0, 0, "R1 R2 zero");

        // R10 R11: load distinct sets per channel
        cur_req = "R10 R11";
        wcoef(0, 0, 4404019);  wcoef(0, 1, -419430); wcoef(0, 2, 209715);
        wcoef(0, 3, 3984589);  wcoef(0, 4, 41943);   wcoef(0, 5, -20972);
        wcoef(0, 6, 4236247);  wcoef(0, 7, -125829); wcoef(0, 8, 83886);
        wcoef(0, 9, -41943);
        wcoef(1, 0, 3984589);  wcoef(1, 1, 629146);  wcoef(1, 2, -104858);
        wcoef(1, 3, 4613734);  wcoef(1, 4, -83886);  wcoef(1, 5, 10486);
        wcoef(1, 6, 4089446);  wcoef(1, 7, 209715);  wcoef(1, 8, -62915);
        wcoef(1, 9, 20972);
        wcoef(1, 12, 1234567); // R10: out-of-map index ignored

        // R4 R5 R6 R7 R11: sweep, alternating channels
        cur_req = "R4 R5 R6 R7 R11";
        for (int i = 0; i < 60; i++) begin
            seed = seed * 1103515245 + 12345;
            send(i % 2, seed >>> 8);
            repeat (10) @(negedge clk);
        end

        // R3 R7: saturation corners
        cur_req = "R3 R7";
        wcoef(0, 0, 8388607); wcoef(0, 3, 8388607); wcoef(0, 4, 8388607);
        send(0, 2097151);  repeat (10) @(negedge clk);
        send(0, -2097152); repeat (10) @(negedge clk);
        wcoef(0, 4, -8388608);
        send(0, -2097152); repeat (10) @(negedge clk);
        send(0, 1);        repeat (10) @(negedge clk);

        // R10: writes issued while busy must not land
        cur_req = "R10";
        send(1, 700000);
        coef_we = 1'b1; coef_chan = 1'b1; coef_idx = 4'd0; coef_data = 24'd8388607;
        repeat (3) @(negedge clk);
        coef_we = 1'b0;
        repeat (8) @(negedge clk);
        send(1, 700000); repeat (10) @(negedge clk);

        // R8 R9: continuous strobe, drops while busy, re-accept at tenth edge
        cur_req = "R8 R9";
        @(negedge clk);
        in_valid = 1'b1; in_chan = 1'b0; in_phase = 22'd500000;
        repeat (25) begin
            @(negedge clk);
            in_phase = in_phase + 22'd1111;
        end
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        cur_req = "R9";
        send(1, -300000); repeat (12) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule